// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Strobe

This block takes a five-digit decimal conversion result and presents it one digit at a time on a shared 4-bit BCD bus. A one-hot set of digit-select lines marks which digit is on the bus. Scanning starts at the most significant digit and walks down to the least significant. The block runs from a clock at twice the conversion count rate, so each digit slot of 201 counts lasts 402 clock cycles.

On the first scan after a new result, each digit slot carries one active-low strobe pulse. The pulse is placed in the middle of the slot, and the bus holds steady on both sides of it. An external latch can therefore capture the digit either on the low level or on an edge. After that first scan the digits keep cycling with the strobe held high, so a display stays refreshed. If the result was flagged over-range, the block stops after the first scan and goes idle.

A new result pulse restarts the scan at the most significant digit, with strobes enabled, at any time.

Top module: `bcd_digit_scanner`

## Requirements
- R1: During and after reset, with no result yet taken, `digit_sel` is all zero, `strobe_n` is 1 and `bcd_out` is 0.
- R2: The clock edge that samples `result_valid` high stores `result_digits`, whose bits [4i+3:4i] hold digit i (i=0 least significant, i=4 most significant). In the next cycle scanning begins at the most significant digit, and `digit_sel` bit 4 is high.
- R3: Each digit slot lasts 402 cycles. The slots run in the order `digit_sel` bit 4, 3, 2, 1, 0, and during slot s only bit (4-s) is high while `bcd_out` carries digit (4-s).
- R4: During the first scan after a result, `strobe_n` is low for exactly one cycle per slot. That cycle is at offset 202 in the slot, counting the slot's first cycle as offset 0. At all other times in that scan `strobe_n` is high.
- R5: `bcd_out` has the same value in the cycle before, the cycle during and the cycle after every strobe-low cycle.
- R6: When the result was not over-range, scanning repeats from bit 4 after the least significant slot without end, with `strobe_n` held high on every repeat scan.
- R7: When `over_range` was high with the result, the block goes idle after the least significant slot of the first scan: `digit_sel` is 0, `strobe_n` is 1 and `bcd_out` is 0 until the next result.
- R8: A `result_valid` pulse at any time, including mid-scan and while idle, restarts scanning at bit 4 with the new digits and with strobes enabled.
- R9: At most one bit of `digit_sel` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the count rate |
| rst | input | 1 | Synchronous active-high reset |
| result_valid | input | 1 | One-cycle pulse: a new result is present |
| result_digits | input | 20 | Five BCD digits, digit 0 in bits [3:0] |
| over_range | input | 1 | Result exceeds range; sampled with `result_valid` |
| bcd_out | output | 4 | Shared BCD bus carrying the selected digit |
| digit_sel | output | 5 | One-hot digit select, bit 4 = most significant |
| strobe_n | output | 1 | Active-low capture strobe, first scan only |

## Verification
The assertions take for granted that `result_valid` is a single-cycle pulse and that `result_digits` and `over_range` are meaningful only in that cycle. They also assume that no result pulse lands in the cycle just after a strobe, since a restart there would legally change the bus. The bench drives every input on the falling clock edge and raises `result_valid` for exactly one cycle. Its restart points are chosen away from strobe offsets, and it supplies only legal BCD values, including the extremes 0 and 9.

// File: rtl/bds_pkg.sv
package bds_pkg;

    localparam int DEF_DIGITS       = 5;
    localparam int DEF_BCD_W        = 4;
    localparam int DEF_SLOT_COUNTS  = 201;
    localparam int DEF_STROBE_COUNT = 101;

    // Two clock cycles per count: the half-count strobe is one cycle wide.
    function automatic int counts_to_cycles(input int counts);
        return 2 * counts;
    endfunction

    function automatic int width_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    typedef struct packed {
        logic active;      // a scan is running
        logic first_pass;  // strobes are enabled
        logic ovr;         // result was flagged over-range
    } scan_mode_t;

endpackage

// File: rtl/scan_slot_timer.sv
module scan_slot_timer #(
    parameter int SLOT_CYC = 402,
    localparam int CW = bds_pkg::width_for(SLOT_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          slot_end
);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_end = run && (cnt == LAST);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && !slot_end) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/scan_digit_sequencer.sv
module scan_digit_sequencer #(
    parameter int NUM_DIGITS = 5,
    localparam int IW = bds_pkg::width_for(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  logic                  over_range,
    input  logic                  slot_end,
    output bds_pkg::scan_mode_t   mode,
    output logic [IW-1:0]         idx
);
    localparam logic [IW-1:0] TOP_IDX = IW'(NUM_DIGITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            idx  <= '0;
        end else if (restart) begin
            mode.active     <= 1'b1;
            mode.first_pass <= 1'b1;
            mode.ovr        <= over_range;
            idx             <= TOP_IDX;
        end else if (slot_end) begin
            if (idx == '0) begin
                mode.first_pass <= 1'b0;
                if (mode.first_pass && mode.ovr) begin
                    mode.active <= 1'b0;
                end else begin
                    idx <= TOP_IDX;
                end
            end else begin
                idx <= idx - 1'b1;
            end
        end
    end

    // R3
    digit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && idx != '0 && !restart) |=> (idx == $past(idx) - 1'b1));

    // R7
    ovr_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && idx == '0 && mode.ovr && !restart) |=> !mode.active);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && idx == '0 && !mode.ovr && !restart)
            |=> (mode.active && !mode.first_pass && idx == TOP_IDX));

endmodule

// File: rtl/scan_output_drive.sv
module scan_output_drive #(
    parameter int NUM_DIGITS = 5,
    parameter int BCD_W      = 4,
    parameter int SLOT_CYC   = 402,
    parameter int STROBE_CYC = 202,
    localparam int CW = bds_pkg::width_for(SLOT_CYC),
    localparam int IW = bds_pkg::width_for(NUM_DIGITS),
    localparam int DW = NUM_DIGITS * BCD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [DW-1:0]         digits_in,
    input  bds_pkg::scan_mode_t   mode,
    input  logic [IW-1:0]         idx,
    input  logic [CW-1:0]         cnt,
    output logic [BCD_W-1:0]      bcd_out,
    output logic [NUM_DIGITS-1:0] digit_sel,
    output logic                  strobe_n
);
    localparam logic [CW-1:0] STB_AT = CW'(STROBE_CYC);
    localparam logic [NUM_DIGITS-1:0] ONE = NUM_DIGITS'(1);

    logic [DW-1:0] digits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q <= '0;
        end else if (load) begin
            digits_q <= digits_in;
        end
    end

    always_comb begin
        if (mode.active) begin
            digit_sel = ONE << idx;
            bcd_out   = digits_q[int'(idx) * BCD_W +: BCD_W];
            strobe_n  = !(mode.first_pass && (cnt == STB_AT));
        end else begin
            digit_sel = '0;
            bcd_out   = '0;
            strobe_n  = 1'b1;
        end
    end

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_sel));

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> strobe_n);

    // R4
    strobe_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> ($countones(digit_sel) == 1));

    // R5
    bus_before_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> $stable(bcd_out));

    // R5
    bus_after_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !load) |=> $stable(bcd_out));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (digit_sel == '0) |-> (strobe_n && bcd_out == '0));

endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
    parameter int NUM_DIGITS   = bds_pkg::DEF_DIGITS,
    parameter int BCD_W        = bds_pkg::DEF_BCD_W,
    parameter int SLOT_COUNTS  = bds_pkg::DEF_SLOT_COUNTS,
    parameter int STROBE_COUNT = bds_pkg::DEF_STROBE_COUNT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          result_valid,
    input  logic [NUM_DIGITS*BCD_W-1:0]   result_digits,
    input  logic                          over_range,
    output logic [BCD_W-1:0]              bcd_out,
    output logic [NUM_DIGITS-1:0]         digit_sel,
    output logic                          strobe_n
);
    localparam int SLOT_CYC   = bds_pkg::counts_to_cycles(SLOT_COUNTS);
    localparam int STROBE_CYC = bds_pkg::counts_to_cycles(STROBE_COUNT);
    localparam int CW         = bds_pkg::width_for(SLOT_CYC);
    localparam int IW         = bds_pkg::width_for(NUM_DIGITS);

    bds_pkg::scan_mode_t mode;
    logic [IW-1:0]       idx;
    logic [CW-1:0]       cnt;
    logic                slot_end;

    scan_slot_timer #(.SLOT_CYC(SLOT_CYC)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (result_valid),
        .run      (mode.active),
        .cnt      (cnt),
        .slot_end (slot_end)
    );

    scan_digit_sequencer #(.NUM_DIGITS(NUM_DIGITS)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .restart    (result_valid),
        .over_range (over_range),
        .slot_end   (slot_end),
        .mode       (mode),
        .idx        (idx)
    );

    scan_output_drive #(
        .NUM_DIGITS (NUM_DIGITS),
        .BCD_W      (BCD_W),
        .SLOT_CYC   (SLOT_CYC),
        .STROBE_CYC (STROBE_CYC)
    ) drive_i (
        .clk       (clk),
        .rst       (rst),
        .load      (result_valid),
        .digits_in (result_digits),
        .mode      (mode),
        .idx       (idx),
        .cnt       (cnt),
        .bcd_out   (bcd_out),
        .digit_sel (digit_sel),
        .strobe_n  (strobe_n)
    );

    // R2
    start_top_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> digit_sel[NUM_DIGITS-1]);

    // R8
    start_strobe_en_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> strobe_n);

endmodule

// File: tb/bcd_digit_scanner_tb_top.sv
module bcd_digit_scanner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 402;
    localparam int STB        = 202;
    localparam int SCAN       = 5 * SLOT;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        result_valid = 1'b0;
    logic [19:0] result_digits = '0;
    logic        over_range = 1'b0;
    logic [3:0]  bcd_out;
    logic [4:0]  digit_sel;
    logic        strobe_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [3:0] caps [0:15];
    int         cap_n = 0;
    int         r5_err = 0;
    logic [3:0] prev_bus = '0;
    logic [3:0] stb_bus = '0;
    bit         after_stb = 0;

    bcd_digit_scanner dut_i (
        .clk           (clk),
        .rst           (rst),
        .result_valid  (result_valid),
        .result_digits (result_digits),
        .over_range    (over_range),
        .bcd_out       (bcd_out),
        .digit_sel     (digit_sel),
        .strobe_n      (strobe_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // Strobe monitor: captures the bus on each strobe and tracks bus steadiness (R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (after_stb) begin
                if (bcd_out !== stb_bus) r5_err++;
                after_stb = 0;
            end
            if (strobe_n === 1'b0) begin
                if (bcd_out !== prev_bus) r5_err++;
                if (cap_n < 16) caps[cap_n] = bcd_out;
                cap_n++;
                stb_bus = bcd_out;
                after_stb = 1;
            end
            prev_bus = bcd_out;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic start_result(input logic [19:0] digs, input logic ovr);
        @(negedge clk);
        result_digits = digs;
        over_range    = ovr;
        result_valid  = 1'b1;
        @(negedge clk);
        result_valid  = 1'b0;
        result_digits = '0;
        over_range    = 1'b0;
        cap_n  = 0;
        r5_err = 0;
    endtask

    // Cycle-by-cycle comparison against the slot schedule given by R3/R4/R6/R7
    task automatic check_window(input logic [19:0] digs, input logic ovr, input int ncyc,
                                input string tag);
        int e_first = 0, e_stb = 0, e_rep = 0, e_idle = 0, e_hot = 0;
        int a_first = 0, x_first = 0;
        for (int k = 0; k < ncyc; k++) begin
            int pass = k / SCAN;
            int s    = (k % SCAN) / SLOT;
            int off  = k % SLOT;
            logic [4:0] xs;
            logic [3:0] xb;
            logic       xst;
            if (ovr && pass >= 1) begin
                xs = '0; xb = '0; xst = 1'b1;
            end else begin
                xs  = 5'(1 << (4 - s));
                xb  = digs[4*(4-s) +: 4];
                xst = !(pass == 0 && off == STB);
            end
            if (!$onehot0(digit_sel)) e_hot++;
            if (ovr && pass >= 1) begin
                if (digit_sel !== xs || bcd_out !== xb || strobe_n !== xst) e_idle++;
            end else if (pass == 0) begin
                if (digit_sel !== xs || bcd_out !== xb) begin
                    if (e_first == 0) begin a_first = int'(digit_sel); x_first = int'(xs); end
                    e_first++;
                end
                if (strobe_n !== xst) e_stb++;
            end else begin
                if (digit_sel !== xs || bcd_out !== xb || strobe_n !== xst) e_rep++;
            end
            @(negedge clk);
        end
        check(e_first == 0, {tag, " R2/R3 first-scan select and bus"}, a_first, x_first);
        check(e_stb == 0, {tag, " R4 strobe placement (mismatch cycles)"}, e_stb, 0);
        check(e_hot == 0, {tag, " R9 one-hot select (bad cycles)"}, e_hot, 0);
        if (ovr)
            check(e_idle == 0, {tag, " R7 idle after over-range (bad cycles)"}, e_idle, 0);
        else if (ncyc > SCAN)
            check(e_rep == 0, {tag, " R6 silent repeat scan (bad cycles)"}, e_rep, 0);
    endtask

    task automatic check_caps(input logic [19:0] digs, input string tag);
        int bad = -1;
        check(cap_n == 5, {tag, " R4 strobe count"}, cap_n, 5);
        for (int i = 0; i < 5; i++)
            if (bad < 0 && caps[i] !== digs[4*(4-i) +: 4]) bad = i;
        check(bad < 0, {tag, " R4 captured digits D5..D1 (first bad position)"}, bad, -1);
        check(r5_err == 0, {tag, " R5 bus steady around strobe"}, r5_err, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(digit_sel == '0, "R1 select low in reset", int'(digit_sel), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(digit_sel == '0, "R1 select low after reset", int'(digit_sel), 0);
        check(strobe_n === 1'b1, "R1 strobe high after reset", int'(strobe_n), 1);
        check(bcd_out == '0, "R1 bus zero after reset", int'(bcd_out), 0);
    endtask

    task automatic t_normal();
        logic [19:0] d = {4'd5, 4'd4, 4'd3, 4'd2, 4'd1};
        start_result(d, 1'b0);
        check_window(d, 1'b0, 2 * SCAN + 300, "normal");
        check_caps(d, "normal");
    endtask

    task automatic t_over_range();
        logic [19:0] d = {4'd9, 4'd8, 4'd7, 4'd6, 4'd0};
        start_result(d, 1'b1);
        check_window(d, 1'b1, SCAN + 500, "overrange");
        check_caps(d, "overrange");
    endtask

    task automatic t_restart_mid();
        logic [19:0] a = {4'd1, 4'd1, 4'd1, 4'd1, 4'd1};
        logic [19:0] b = {4'd0, 4'd9, 4'd0, 4'd9, 4'd0};
        start_result(a, 1'b0);
        repeat (1000) @(negedge clk);
        start_result(b, 1'b0);
        check_window(b, 1'b0, SCAN + 100, "R8 restart mid-scan");
        check_caps(b, "R8 restart mid-scan");
    endtask

    task automatic t_restart_idle();
        logic [19:0] d = {4'd7, 4'd3, 4'd9, 4'd2, 4'd6};
        start_result(d, 1'b1);
        repeat (SCAN + 50) @(negedge clk);
        check(digit_sel == '0, "R7 idle before restart", int'(digit_sel), 0);
        start_result(d, 1'b0);
        check_window(d, 1'b0, SCAN + 200, "R8 restart from idle");
        check_caps(d, "R8 restart from idle");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_over_range();
        t_restart_mid();
        t_restart_idle();
        finish_run();
    end

endmodule